// File: doc/BRIEF.md
# PCI Single-Data-Phase Disconnect Target

This block is the 32-bit PCI target engine of a network controller. It claims bus cycles aimed at two regions: a small control/status register window, which can be reached through either a memory or an I/O address, and a 128 KB flash buffer window in memory space. Each burst it claims ends after exactly one data transfer. The block asserts STOP together with TRDY in that data phase, so an initiator that wants more data has to start a new transaction.

Register reads and writes, and flash writes, are given TRDY in the same clock that DEVSEL is asserted. A flash read is different. It raises a request on a simple request/acknowledge flash port and keeps TRDY deasserted for a minimum number of wait clocks, set by a parameter, or longer if the flash acknowledge is late. The captured word is driven onto AD only in the clock where TRDY is asserted. The initiator can stretch any data phase by holding IRDY deasserted.

Top module: `pci_one_phase_target`

## Requirements
- R1: While reset is held and after it is released, with no bus activity, devsel_n, trdy_n and stop_n are high; tgt_oe, ad_oe, csr_wr, csr_rd, fl_wr and fl_req are low.
- R2: The address phase is the clock where frame_n is first sampled low. devsel_n goes low so that it is first sampled low at the second rising edge after that clock (medium decode). The block claims only these cases: an I/O read (C/BE# 0010) or I/O write (0011) inside the register I/O window; a memory read (0110) or memory write (0111) inside the register memory window; a memory read or write inside the 128 KB flash window.
- R3: Any other command, or any address outside the windows, is never claimed: devsel_n stays high and no register or flash strobe fires.
- R4: A register access takes exactly one data phase. TRDY is asserted in the first clock of DEVSEL. On a write, csr_wr pulses in the completing clock with the byte offset, the AD data and the byte enables (inverted C/BE#).
- R5: STOP is low in every clock in which TRDY is low. In the clock after completion, devsel_n, trdy_n and stop_n are all high while tgt_oe stays high for one turnaround clock. tgt_oe is released once frame_n has been sampled high.
- R6: A data phase completes only on an edge where irdy_n and trdy_n are both low. TRDY and STOP are held until then.
- R7: On a flash read, TRDY stays deasserted while DEVSEL is asserted for max(FLASH_WAIT, L) clocks. Here L is the clock of fl_req's assertion in which fl_ack is sampled high.
- R8: ad_oe is high only while trdy_n is low. On a flash read, ad_out carries the word captured on fl_ack.
- R9: While fl_req is high, fl_addr is the low 17 address bits and fl_be is the inverted C/BE#. A single set bit selects a byte read; two set bits select a 16-bit read.
- R10: A flash write receives TRDY and STOP in the first DEVSEL clock. fl_wr pulses in the completing clock with fl_addr, fl_wdata and fl_be.
- R11: On a register read, ad_out equals csr_rdata for csr_off in the completing clock, and csr_rd pulses in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Initiator cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | 32 | Address/data lines as received |
| cbe_n | input | 4 | Command in address phase, byte enables in data phase, active low |
| ad_out | output | 32 | Read data toward AD |
| ad_oe | output | 1 | Enable for driving ad_out |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop request, active low |
| tgt_oe | output | 1 | Enable for driving devsel_n, trdy_n, stop_n |
| csr_wr | output | 1 | Register write strobe |
| csr_rd | output | 1 | Register read strobe |
| csr_off | output | CSR_AW | Register byte offset |
| csr_wdata | output | 32 | Register write data |
| csr_be | output | 4 | Register byte enables, active high |
| csr_rdata | input | 32 | Register read data for csr_off |
| fl_req | output | 1 | Flash read request, held until acknowledge |
| fl_wr | output | 1 | Flash write strobe |
| fl_addr | output | FLASH_AW | Flash byte address |
| fl_wdata | output | 32 | Flash write data |
| fl_be | output | 4 | Flash byte enables, active high |
| fl_ack | input | 1 | Flash read acknowledge, data valid |
| fl_rdata | input | 32 | Flash read data |

## Verification
Call the clock whose rising edge first sees frame_n low the address clock. The falling-edge monitor numbers its samples from that clock. DEVSEL must appear at sample 2. For register accesses and flash writes, TRDY is due at sample 2. For flash reads, TRDY is due at sample 2 plus max(FLASH_WAIT, L). Completion comes at the later of TRDY and the driver's IRDY sample. The turnaround is checked one sample after completion and the release of tgt_oe one sample after that. For every transaction the driver computes these sample numbers, the expected count of TRDY-low clocks, and the expected data, and pushes them into the scoreboard before it drives the bus. The monitor compares them only at those samples.

// File: rtl/pst_pkg.sv
package pst_pkg;

    localparam int DW = 32;
    localparam int BEW = DW / 8;

    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEC,
        ST_IGN,
        ST_XFER,
        ST_FWAIT,
        ST_FDATA,
        ST_TURN
    } pst_state_e;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_CSR,
        RGN_FLASH
    } region_e;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [3:0]    cmd;
    } bus_txn_t;

    function automatic logic cmd_is_mem(input logic [3:0] cmd);
        return cmd[3:1] == CMD_MEM_RD[3:1];
    endfunction

    function automatic logic cmd_is_io(input logic [3:0] cmd);
        return cmd[3:1] == CMD_IO_RD[3:1];
    endfunction

endpackage

// File: rtl/pst_decode.sv
module pst_decode
    import pst_pkg::*;
#(
    parameter logic [31:0] CSR_MEM_BASE = 32'hFEB0_0000,
    parameter logic [31:0] CSR_IO_BASE  = 32'h0000_E000,
    parameter int          CSR_AW       = 6,
    parameter logic [31:0] FLASH_BASE   = 32'hFEA0_0000,
    parameter int          FLASH_AW     = 17
) (
    input  bus_txn_t txn,
    output region_e  region,
    output logic     is_wr
);
    logic mem_cmd, io_cmd;
    logic csr_mem_hit, csr_io_hit, flash_hit;

    always_comb begin
        mem_cmd     = cmd_is_mem(txn.cmd);
        io_cmd      = cmd_is_io(txn.cmd);
        csr_mem_hit = mem_cmd && (txn.addr[DW-1:CSR_AW] == CSR_MEM_BASE[DW-1:CSR_AW]);
        csr_io_hit  = io_cmd  && (txn.addr[DW-1:CSR_AW] == CSR_IO_BASE[DW-1:CSR_AW]);
        flash_hit   = mem_cmd && (txn.addr[DW-1:FLASH_AW] == FLASH_BASE[DW-1:FLASH_AW]);
        is_wr       = txn.cmd[0];
        if (csr_mem_hit || csr_io_hit) begin
            region = RGN_CSR;
        end else if (flash_hit) begin
            region = RGN_FLASH;
        end else begin
            region = RGN_NONE;
        end
    end
endmodule

// File: rtl/pst_flash_rd.sv
module pst_flash_rd
    import pst_pkg::*;
#(
    parameter int FLASH_WAIT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          active,
    input  logic          fl_ack,
    input  logic [DW-1:0] fl_rdata,
    output logic          fl_req,
    output logic          ready,
    output logic [DW-1:0] data
);
    localparam int CW = $clog2(FLASH_WAIT + 1);

    logic [CW-1:0] wait_cnt;
    logic          got_q;
    logic          min_met;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            wait_cnt <= '0;
            got_q    <= 1'b0;
        end else if (active) begin
            if (wait_cnt != CW'(FLASH_WAIT)) begin
                wait_cnt <= wait_cnt + 1'b1;
            end
            if (fl_ack && !got_q) begin
                got_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (active && fl_ack && !got_q) begin
            data <= fl_rdata;
        end
    end

    always_comb begin
        min_met = (int'(wait_cnt) + 1) >= FLASH_WAIT;
        fl_req  = active && !got_q;
        ready   = active && min_met && (got_q || fl_ack);
    end
endmodule

// File: rtl/pci_one_phase_target.sv
module pci_one_phase_target
    import pst_pkg::*;
#(
    parameter logic [31:0] CSR_MEM_BASE = 32'hFEB0_0000,
    parameter logic [31:0] CSR_IO_BASE  = 32'h0000_E000,
    parameter int          CSR_AW       = 6,
    parameter logic [31:0] FLASH_BASE   = 32'hFEA0_0000,
    parameter int          FLASH_AW     = 17,
    parameter int          FLASH_WAIT   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_n,
    input  logic                irdy_n,
    input  logic [31:0]         ad_in,
    input  logic [3:0]          cbe_n,
    output logic [31:0]         ad_out,
    output logic                ad_oe,
    output logic                devsel_n,
    output logic                trdy_n,
    output logic                stop_n,
    output logic                tgt_oe,
    output logic                csr_wr,
    output logic                csr_rd,
    output logic [CSR_AW-1:0]   csr_off,
    output logic [31:0]         csr_wdata,
    output logic [3:0]          csr_be,
    input  logic [31:0]         csr_rdata,
    output logic                fl_req,
    output logic                fl_wr,
    output logic [FLASH_AW-1:0] fl_addr,
    output logic [31:0]         fl_wdata,
    output logic [3:0]          fl_be,
    input  logic                fl_ack,
    input  logic [31:0]         fl_rdata
);
    pst_state_e st_q, st_d;
    bus_txn_t   txn_q;
    region_e    region;
    logic       is_wr;
    logic       claimed, data_ok, xfer_done;
    logic       fr_start, fr_active, fr_ready;
    logic [DW-1:0] fr_data;

    pst_decode #(
        .CSR_MEM_BASE(CSR_MEM_BASE),
        .CSR_IO_BASE (CSR_IO_BASE),
        .CSR_AW      (CSR_AW),
        .FLASH_BASE  (FLASH_BASE),
        .FLASH_AW    (FLASH_AW)
    ) u_dec (
        .txn   (txn_q),
        .region(region),
        .is_wr (is_wr)
    );

    pst_flash_rd #(
        .FLASH_WAIT(FLASH_WAIT)
    ) u_frd (
        .clk     (clk),
        .rst     (rst),
        .start   (fr_start),
        .active  (fr_active),
        .fl_ack  (fl_ack),
        .fl_rdata(fl_rdata),
        .fl_req  (fl_req),
        .ready   (fr_ready),
        .data    (fr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            txn_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && !frame_n) begin
                txn_q <= '{addr: ad_in, cmd: cbe_n};
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (!frame_n) st_d = ST_DEC;
            ST_DEC: begin
                if (region == RGN_NONE) begin
                    st_d = ST_IGN;
                end else if (region == RGN_FLASH && !is_wr) begin
                    st_d = ST_FWAIT;
                end else begin
                    st_d = ST_XFER;
                end
            end
            ST_IGN:   if (frame_n && irdy_n) st_d = ST_IDLE;
            ST_XFER:  if (!irdy_n) st_d = ST_TURN;
            ST_FWAIT: if (fr_ready) st_d = ST_FDATA;
            ST_FDATA: if (!irdy_n) st_d = ST_TURN;
            ST_TURN:  if (frame_n) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fr_start  = (st_q == ST_DEC) && (st_d == ST_FWAIT);
        fr_active = (st_q == ST_FWAIT);
        claimed   = (st_q == ST_XFER) || (st_q == ST_FWAIT) || (st_q == ST_FDATA);
        data_ok   = (st_q == ST_XFER) || (st_q == ST_FDATA);
        xfer_done = (st_q == ST_XFER) && !irdy_n;

        devsel_n  = !claimed;
        trdy_n    = !data_ok;
        stop_n    = !data_ok;
        tgt_oe    = claimed || (st_q == ST_TURN);

        csr_wr    = xfer_done && (region == RGN_CSR) && is_wr;
        csr_rd    = xfer_done && (region == RGN_CSR) && !is_wr;
        fl_wr     = xfer_done && (region == RGN_FLASH) && is_wr;

        csr_off   = txn_q.addr[CSR_AW-1:0];
        csr_wdata = ad_in;
        csr_be    = ~cbe_n;
        fl_addr   = txn_q.addr[FLASH_AW-1:0];
        fl_wdata  = ad_in;
        fl_be     = ~cbe_n;

        ad_oe     = ((st_q == ST_XFER) && (region == RGN_CSR) && !is_wr) || (st_q == ST_FDATA);
        if (st_q == ST_FDATA) begin
            ad_out = fr_data;
        end else if (ad_oe) begin
            ad_out = csr_rdata;
        end else begin
            ad_out = '0;
        end
    end
endmodule

// File: rtl/pst_checks.sv
module pst_checks (
    input logic clk,
    input logic rst,
    input logic frame_n,
    input logic irdy_n,
    input logic devsel_n,
    input logic trdy_n,
    input logic stop_n,
    input logic tgt_oe,
    input logic ad_oe,
    input logic csr_wr,
    input logic csr_rd,
    input logic fl_wr,
    input logic fl_req
);
    p_stop_with_trdy_r5: assert property (@(posedge clk) disable iff (rst)
        !trdy_n |-> !stop_n);

    p_drive_while_claimed_r5: assert property (@(posedge clk) disable iff (rst)
        !devsel_n |-> tgt_oe);

    p_single_phase_r4: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n && !irdy_n) |=> (trdy_n && stop_n && devsel_n));

    p_ad_with_trdy_r8: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> !trdy_n);

    p_medium_decode_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n) |-> !$past(frame_n, 2));

    p_req_during_wait_r7: assert property (@(posedge clk) disable iff (rst)
        fl_req |-> (!devsel_n && trdy_n));

    p_csr_strobe_done_r6: assert property (@(posedge clk) disable iff (rst)
        (csr_wr || csr_rd) |-> (!trdy_n && !irdy_n));

    p_flash_wr_done_r10: assert property (@(posedge clk) disable iff (rst)
        fl_wr |-> (!trdy_n && !irdy_n));
endmodule

bind pci_one_phase_target pst_checks u_checks (
    .clk     (clk),
    .rst     (rst),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .devsel_n(devsel_n),
    .trdy_n  (trdy_n),
    .stop_n  (stop_n),
    .tgt_oe  (tgt_oe),
    .ad_oe   (ad_oe),
    .csr_wr  (csr_wr),
    .csr_rd  (csr_rd),
    .fl_wr   (fl_wr),
    .fl_req  (fl_req)
);

// File: tb/sim_pci_one_phase_target.sv
`timescale 1ns/1ps
module sim_pci_one_phase_target;
    localparam int W = 3;
    localparam int K_CSR_WR = 0;
    localparam int K_CSR_RD = 1;
    localparam int K_FL_WR  = 2;
    localparam int K_FL_RD  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1, irdy_n = 1'b1;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_out, csr_wdata, csr_rdata, fl_wdata, fl_rdata;
    logic        ad_oe, devsel_n, trdy_n, stop_n, tgt_oe;
    logic        csr_wr, csr_rd, fl_req, fl_wr, fl_ack;
    logic [5:0]  csr_off;
    logic [3:0]  csr_be, fl_be;
    logic [16:0] fl_addr;

    int checks = 0, fails = 0;
    int fl_lat = 1, req_age = 0;

    typedef struct {
        int          kind;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        int          waits;
        int          tcyc;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] csr_model(input logic [5:0] off);
        return 32'hC0DE_0000 | {26'h0, off};
    endfunction

    function automatic logic [31:0] fl_model(input logic [16:0] a);
        return 32'h0F1A_0000 ^ {15'h0, a};
    endfunction

    assign csr_rdata = csr_model(csr_off);
    assign fl_rdata  = fl_model(fl_addr);
    assign fl_ack    = fl_req && (req_age == fl_lat - 1);

    always @(posedge clk) begin
        if (rst || !fl_req) req_age <= 0;
        else req_age <= req_age + 1;
    end

    pci_one_phase_target #(.FLASH_WAIT(W)) u0 (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .tgt_oe(tgt_oe),
        .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_off(csr_off), .csr_wdata(csr_wdata),
        .csr_be(csr_be), .csr_rdata(csr_rdata), .fl_req(fl_req), .fl_wr(fl_wr),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_be(fl_be), .fl_ack(fl_ack),
        .fl_rdata(fl_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: samples on falling edges, pops scoreboard on completion
    int  k = 0, wait_cnt = 0, trdy_cnt = 0, turn_st = 0;
    bit  prev_frame = 1'b1, dv_seen = 1'b0, fl_seen = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!frame_n && prev_frame) begin
                k = 0; wait_cnt = 0; trdy_cnt = 0; dv_seen = 0; fl_seen = 0;
            end else begin
                k++;
            end
            if (!devsel_n && !dv_seen) begin
                dv_seen = 1;
                chk(k == 2, "R2 devsel medium timing", k, 2);
            end
            if (!devsel_n && trdy_n) wait_cnt++;
            if (!devsel_n) chk(!(ad_oe && trdy_n), "R8 AD driven before TRDY", ad_oe, 0);
            if (!trdy_n) begin
                trdy_cnt++;
                chk(!stop_n, "R5 STOP with TRDY", stop_n, 0);
            end
            if (fl_req && !fl_seen && sb.size() > 0) begin
                fl_seen = 1;
                chk(fl_addr == sb[0].addr[16:0], "R9 flash addr", fl_addr, sb[0].addr[16:0]);
                chk(fl_be == sb[0].be, "R9 flash byte enables", fl_be, sb[0].be);
            end
            if (turn_st == 2) begin
                chk(!tgt_oe, "R5 release after frame high", tgt_oe, 0);
                turn_st = 0;
            end
            if (turn_st == 1) begin
                chk(devsel_n && trdy_n && stop_n, "R5 turnaround deassert",
                    {devsel_n, trdy_n, stop_n}, 3'b111);
                chk(tgt_oe, "R5 turnaround drive", tgt_oe, 1);
                turn_st = 2;
            end
            if (!trdy_n && !irdy_n) begin
                if (sb.size() == 0) begin
                    chk(0, "R3 unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(wait_cnt == e.waits, "R7 target wait clocks", wait_cnt, e.waits);
                    chk(trdy_cnt == e.tcyc, "R6 TRDY clocks until IRDY", trdy_cnt, e.tcyc);
                    case (e.kind)
                        K_CSR_WR: begin
                            chk(csr_wr && !fl_wr, "R4 csr write strobe", csr_wr, 1);
                            chk(csr_off == e.addr[5:0], "R4 csr offset", csr_off, e.addr[5:0]);
                            chk(csr_wdata == e.data, "R4 csr wdata", csr_wdata, e.data);
                            chk(csr_be == e.be, "R4 csr be", csr_be, e.be);
                        end
                        K_CSR_RD: begin
                            chk(csr_rd && ad_oe, "R11 csr read strobe", {csr_rd, ad_oe}, 2'b11);
                            chk(ad_out == e.data, "R11 csr read data", ad_out, e.data);
                        end
                        K_FL_WR: begin
                            chk(fl_wr && !csr_wr, "R10 flash write strobe", fl_wr, 1);
                            chk(fl_addr == e.addr[16:0], "R10 flash write addr", fl_addr, e.addr[16:0]);
                            chk(fl_wdata == e.data, "R10 flash wdata", fl_wdata, e.data);
                            chk(fl_be == e.be, "R10 flash be", fl_be, e.be);
                        end
                        default: begin
                            chk(ad_oe, "R8 flash data driven", ad_oe, 1);
                            chk(ad_out == e.data, "R8 flash read data", ad_out, e.data);
                        end
                    endcase
                    turn_st = 1;
                end
            end
        end
        prev_frame = frame_n;
    end

    // Driver: pushes the expected item, then runs one transaction
    task automatic run_txn(input int kind, input logic [3:0] cmd, input logic [31:0] addr,
                           input logic [31:0] wdata, input logic [3:0] be,
                           input int d, input int lat);
        exp_t e;
        int   tstart, istart, done;
        e.kind  = kind;
        e.addr  = addr;
        e.be    = be;
        e.waits = (kind == K_FL_RD) ? ((lat > W) ? lat : W) : 0;
        case (kind)
            K_CSR_RD: e.data = csr_model(addr[5:0]);
            K_FL_RD:  e.data = fl_model(addr[16:0]);
            default:  e.data = wdata;
        endcase
        tstart = 2 + e.waits;
        istart = 1 + d;
        done   = (tstart > istart) ? tstart : istart;
        e.tcyc = done - tstart + 1;
        sb.push_back(e);
        fl_lat = lat;

        @(posedge clk); #1;
        frame_n = 1'b0; ad_in = addr; cbe_n = cmd;
        @(posedge clk); #1;
        ad_in = wdata; cbe_n = ~be;
        if (d > 0) begin
            repeat (d) @(posedge clk);
            #1;
        end
        irdy_n = 1'b0; frame_n = 1'b1;
        do @(negedge clk); while (trdy_n !== 1'b0);
        @(posedge clk); #1;
        irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
        repeat (3) @(posedge clk);
    endtask

    task automatic run_miss(input logic [3:0] cmd, input logic [31:0] addr);
        @(posedge clk); #1;
        frame_n = 1'b0; ad_in = addr; cbe_n = cmd;
        @(posedge clk); #1;
        irdy_n = 1'b0; frame_n = 1'b1; cbe_n = 4'h0; ad_in = 32'h1234_5678;
        repeat (4) begin
            @(negedge clk);
            chk(devsel_n, "R3 unclaimed devsel", devsel_n, 1);
            chk(!(csr_wr || csr_rd || fl_wr || fl_req), "R3 unclaimed strobes",
                {csr_wr, csr_rd, fl_wr, fl_req}, 0);
        end
        @(posedge clk); #1;
        irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(devsel_n && trdy_n && stop_n && !tgt_oe && !ad_oe, "R1 reset outputs",
            {devsel_n, trdy_n, stop_n, tgt_oe, ad_oe}, 5'b11100);
        @(posedge clk); #1 rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!(csr_wr || csr_rd || fl_wr || fl_req) && devsel_n && !tgt_oe, "R1 idle after reset",
            {csr_wr, csr_rd, fl_wr, fl_req, devsel_n, tgt_oe}, 6'b000010);

        run_txn(K_CSR_WR, 4'b0111, 32'hFEB0_0014, 32'hA5A5_0001, 4'b1111, 0, 1); // R4 memory write
        run_txn(K_CSR_WR, 4'b0011, 32'h0000_E010, 32'h5555_AAAA, 4'b0011, 3, 1); // R4 I/O write, R6
        run_txn(K_CSR_RD, 4'b0110, 32'hFEB0_0028, 32'h0, 4'b1111, 0, 1);         // R11 memory read
        run_txn(K_CSR_RD, 4'b0010, 32'h0000_E03C, 32'h0, 4'b1111, 1, 1);         // R11 I/O read
        run_txn(K_FL_RD,  4'b0110, 32'hFEA0_1002, 32'h0, 4'b0100, 0, 1);         // R7 byte, wait=W
        run_txn(K_FL_RD,  4'b0110, 32'hFEA1_FFFC, 32'h0, 4'b0011, 0, 5);         // R7 word, late ack
        run_txn(K_FL_RD,  4'b0110, 32'hFEA0_0400, 32'h0, 4'b1111, 7, 3);         // R6 late IRDY
        run_txn(K_FL_WR,  4'b0111, 32'hFEA0_8008, 32'hDEAD_0F0F, 4'b1100, 0, 1); // R10
        run_txn(K_FL_WR,  4'b0111, 32'hFEA0_0010, 32'h0BAD_F00D, 4'b0001, 2, 1); // R10 with wait
        run_miss(4'b0110, 32'hFEC0_0000);  // R3 no window
        run_miss(4'b1010, 32'hFEB0_0000);  // R3 other command
        run_miss(4'b0010, 32'hFEA0_0000);  // R3 I/O command on flash window
        run_miss(4'b0111, 32'h0000_E000);  // R3 memory command on I/O window
        run_txn(K_CSR_WR, 4'b0111, 32'hFEB0_003C, 32'h0000_00FF, 4'b1000, 0, 1); // R4 after misses

        repeat (4) @(posedge clk);
        chk(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule